// File: doc/BRIEF.md
# Processor interrupt request controller

This block gathers six active-low interrupt request lines into one interrupt line for a processor. Two of the lines come from inside the system: a missing-acknowledge timeout and a mark event. Four come from external devices. The interrupt line is raised only while the processor's interrupt-enable output is high. It rises only after the combined request has stayed present for a programmable number of clock cycles. This clocked delay takes the place of an analog settling network.

The block also latches four bits of the processor's status word whenever the status strobe is high. When those bits show an interrupt-acknowledge cycle, the block freezes the identity of the highest-priority pending source into a 3-bit vector. It then holds the processor in a wait state. The wait is released once a consumer has taken the vector through a valid/ready handshake.

The vector output follows valid/ready rules. While `vec_valid` is high and `vec_ready` is low, the code does not change and the wait stays in force. A transfer happens on a rising clock edge where both are high. The wait is released in the cycle after that edge. No new vector is offered until the next acknowledge.

Top module: `intreq_ctrl`

## Requirements
- R1: The combined request is present exactly when at least one of the six `src_n` bits is low. With all six high, `irq_out` never rises.
- R2: `irq_out` rises after the `DLY`-th consecutive rising edge (default 4) at which a request is present and `int_en` is high. It then stays high while both conditions hold.
- R3: After any edge at which `int_en` is low or no request is present, `irq_out` is low and the delay count restarts from zero. A request shorter than `DLY` edges therefore never raises it.
- R4: On each edge with `sync_stb` high, `st_lat` takes the value of `st_in`, where `st_in` carries data bus bits {7,4,1,0} with bit 0 as the interrupt-acknowledge flag. Without the strobe, `st_lat` holds its value.
- R5: An edge with `sync_stb` high and `st_in[0]` high, while no vector is pending, makes `vec_valid` and `hold_wait` high after that edge.
- R6: The vector code is the index of the highest-priority pending source at the acknowledge edge. The order is `src_n[0]` (acknowledge-missing, code 0), then `src_n[1]` (mark, code 1), then external lines 0 to 3 on `src_n[5:2]` (codes 2 to 5).
- R7: If no source is pending at the acknowledge edge, the code is 7.
- R8: While `vec_valid` is high and `vec_ready` is low, `vec_valid`, `hold_wait` and `vec_code` stay unchanged. This holds even if the sources change or another acknowledge strobe arrives.
- R9: After an edge with `vec_valid` and `vec_ready` both high, `vec_valid` and `hold_wait` are low.
- R10: A status strobe with `st_in[0]` low never starts a wait.
- R11: After reset, `irq_out`, `vec_valid`, `hold_wait` and `st_lat` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_n | input | 6 | Request lines, active low; bit 0 highest priority |
| int_en | input | 1 | Processor interrupt enable |
| sync_stb | input | 1 | Status word strobe |
| st_in | input | 4 | Data bus bits {7,4,1,0}; bit 0 marks interrupt acknowledge |
| vec_ready | input | 1 | Vector consumer ready |
| irq_out | output | 1 | Interrupt line to the processor |
| st_lat | output | 4 | Latched status bits |
| vec_valid | output | 1 | Vector offered |
| vec_code | output | 3 | Priority code of the source being serviced |
| hold_wait | output | 1 | Holds the processor in its wait state |

## Verification
All 64 patterns of the six request lines are applied twice. In the first pass each pattern is held with interrupts enabled. This separates the case where the line rises at exactly the `DLY`-th edge from a rise one edge early or late, and from a rise with no request at all. In the second pass each pattern is acknowledged, and this tells apart every possible priority ordering as well as the empty case. All 16 status nibbles are strobed in to prove that each bit lands in its own position and that only the acknowledge bit starts a wait. Directed runs cover withheld readiness while the sources and strobes keep changing, requests cut short, and interrupt enable dropping and returning.

// File: rtl/intreq_pkg.sv
package intreq_pkg;
  typedef enum logic {
    W_IDLE = 1'b0,
    W_VEC  = 1'b1
  } wait_st_t;

  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned ST_BITS = 4;
  localparam int unsigned ST_ACK  = 0;
endpackage

// File: rtl/intreq_delay.sv
module intreq_delay #(
  parameter int unsigned DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_any,
  input  logic gate_en,
  output logic irq
);
  localparam int unsigned CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic          arm;
  logic [CW-1:0] cnt;

  assign arm = req_any & gate_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (!arm) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (!irq) begin
      if (cnt == LAST) irq <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R3: losing enable or request drops the line at the next edge
  p_gate_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_any && gate_en) |=> !irq);
  // R2: a rise always follows an armed edge
  p_rise_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(req_any && gate_en));
  // R2: once up, stays up while armed
  p_hold_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && req_any && gate_en) |=> irq);
endmodule

// File: rtl/intreq_status.sv
module intreq_status #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (stb) q <= din;
  end

  // R4: capture on strobe, hold otherwise
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> q == $past(din));
  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(q));
endmodule

// File: rtl/intreq_prio.sv
module intreq_prio #(
  parameter int unsigned N  = 6,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  req,
  output logic [CW-1:0] code
);
  localparam logic [CW-1:0] NONE = '1;

  logic [N-1:0] grant;

  for (genvar i = 0; i < N; i++) begin : g_grant
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_rest
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  always_comb begin
    code = NONE;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = CW'(i);
    end
  end

  // R6: at most one source wins
  always_comb begin
    p_onehot_grant_r6: assert ($onehot0(grant));
    // R7: empty request set yields the all-ones code
    if (req == '0) p_none_code_r7: assert (code == NONE);
  end
endmodule

// File: rtl/intreq_ctrl.sv
module intreq_ctrl
  import intreq_pkg::*;
#(
  parameter int unsigned DLY = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [5:0]   src_n,
  input  logic         int_en,
  input  logic         sync_stb,
  input  logic [3:0]   st_in,
  input  logic         vec_ready,
  output logic         irq_out,
  output logic [3:0]   st_lat,
  output logic         vec_valid,
  output logic [2:0]   vec_code,
  output logic         hold_wait
);
  localparam int unsigned CW = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] req;
  logic               req_any;
  logic [CW-1:0]      enc_code;
  logic               ack_hit;
  wait_st_t           st;
  logic [CW-1:0]      code_q;

  assign req     = ~src_n;
  assign req_any = |req;
  assign ack_hit = sync_stb & st_in[ST_ACK];

  intreq_delay #(.DLY(DLY)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_any (req_any),
    .gate_en (int_en),
    .irq     (irq_out)
  );

  intreq_status #(.W(ST_BITS)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (sync_stb),
    .din   (st_in),
    .q     (st_lat)
  );

  intreq_prio #(.N(NUM_SRC), .CW(CW)) u_prio (
    .req  (req),
    .code (enc_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      code_q <= '0;
    end else begin
      case (st)
        W_IDLE: if (ack_hit) begin
          st     <= W_VEC;
          code_q <= enc_code;
        end
        W_VEC: if (vec_ready) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign vec_valid = (st == W_VEC);
  assign hold_wait = (st == W_VEC);
  assign vec_code  = code_q;

  // R5: acknowledge while idle opens a wait with a vector
  p_ack_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid && ack_hit) |=> (vec_valid && hold_wait));
  // R6: frozen code matches the encoder at the acknowledge edge
  p_code_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid && ack_hit) |=> vec_code == $past(enc_code));
  // R8: back-pressure keeps the offer intact
  p_backpress_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && hold_wait && $stable(vec_code)));
  // R9: transfer ends the wait
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> (!vec_valid && !hold_wait));
  // R10: no acknowledge, no wait
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid && !ack_hit) |=> !vec_valid);
endmodule

// File: tb/intreq_ctrl_tb_top.sv
module intreq_ctrl_tb_top;
  localparam int unsigned DLY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src_n = 6'h3F;
  logic       int_en = 1'b0;
  logic       sync_stb = 1'b0;
  logic [3:0] st_in = 4'h0;
  logic       vec_ready = 1'b0;
  logic       irq_out;
  logic [3:0] st_lat;
  logic       vec_valid;
  logic [2:0] vec_code;
  logic       hold_wait;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intreq_ctrl #(.DLY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_n(src_n), .int_en(int_en),
    .sync_stb(sync_stb), .st_in(st_in), .vec_ready(vec_ready),
    .irq_out(irq_out), .st_lat(st_lat), .vec_valid(vec_valid),
    .vec_code(vec_code), .hold_wait(hold_wait)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [5:0] p);
    for (int i = 0; i < 6; i++) if (!p[i]) return i;
    return 7;
  endfunction

  task automatic ack_and_take(input logic [5:0] p, input string rq);
    src_n = p; st_in = 4'b0001; sync_stb = 1'b1;
    tick();
    sync_stb = 1'b0;
    chk(vec_valid && hold_wait, "R5", {vec_valid, hold_wait}, 3);
    chk(vec_code == 3'(exp_code(p)), rq, vec_code, exp_code(p));
    vec_ready = 1'b1;
    tick();
    vec_ready = 1'b0;
    chk(!vec_valid && !hold_wait, "R9", {vec_valid, hold_wait}, 0);
  endtask

  initial begin
    repeat (3) tick();
    // R11: reset state
    chk({irq_out, vec_valid, hold_wait} == 3'b000, "R11", {irq_out, vec_valid, hold_wait}, 0);
    chk(st_lat == 4'h0, "R11", st_lat, 0);
    rst_n = 1'b1;
    tick();

    // R1/R2/R3: delay sweep over all request patterns
    for (int p = 0; p < 64; p++) begin
      src_n = 6'(p); int_en = 1'b1;
      for (int k = 1; k <= DLY + 1; k++) begin
        tick();
        if (p == 63)
          chk(irq_out == 1'b0, "R1", irq_out, 0);
        else
          chk(irq_out == (k >= DLY), "R2", irq_out, int'(k >= DLY));
      end
      int_en = 1'b0;
      tick();
      chk(irq_out == 1'b0, "R3", irq_out, 0);
    end

    // R3: request held but enable low never raises the line
    src_n = 6'h3E; int_en = 1'b0;
    for (int k = 0; k < DLY + 2; k++) begin
      tick();
      chk(irq_out == 1'b0, "R3", irq_out, 0);
    end
    // R3: short request then full restart
    int_en = 1'b1;
    for (int k = 1; k < DLY; k++) tick();
    src_n = 6'h3F;
    tick();
    chk(irq_out == 1'b0, "R3", irq_out, 0);
    src_n = 6'h37;
    for (int k = 1; k <= DLY; k++) begin
      tick();
      chk(irq_out == (k == DLY), "R3", irq_out, int'(k == DLY));
    end
    // R3: enable drop and return needs full delay again
    int_en = 1'b0;
    tick();
    chk(irq_out == 1'b0, "R3", irq_out, 0);
    int_en = 1'b1;
    for (int k = 1; k <= DLY; k++) begin
      tick();
      chk(irq_out == (k == DLY), "R3", irq_out, int'(k == DLY));
    end
    int_en = 1'b0; src_n = 6'h3F;
    tick();

    // R6/R7: priority sweep over every pattern
    for (int p = 0; p < 64; p++)
      ack_and_take(6'(p), (p == 63) ? "R7" : "R6");

    // R4/R10: every status nibble
    for (int v = 0; v < 16; v++) begin
      src_n = 6'h3B; st_in = 4'(v); sync_stb = 1'b1;
      tick();
      sync_stb = 1'b0;
      chk(st_lat == 4'(v), "R4", st_lat, v);
      if (v[0]) begin
        chk(vec_valid && hold_wait, "R5", {vec_valid, hold_wait}, 3);
        vec_ready = 1'b1;
        tick();
        vec_ready = 1'b0;
      end else begin
        chk(!vec_valid && !hold_wait, "R10", {vec_valid, hold_wait}, 0);
      end
      st_in = ~4'(v);
      tick();
      chk(st_lat == 4'(v), "R4", st_lat, v);
    end

    // R8: back-pressure with changing sources and a second acknowledge
    src_n = 6'h3B; st_in = 4'b0001; sync_stb = 1'b1;
    tick();
    sync_stb = 1'b0;
    chk(vec_code == 3'd2, "R6", vec_code, 2);
    src_n = 6'h3E; sync_stb = 1'b1;
    tick();
    sync_stb = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(vec_valid && hold_wait, "R8", {vec_valid, hold_wait}, 3);
      chk(vec_code == 3'd2, "R8", vec_code, 2);
      tick();
    end
    vec_ready = 1'b1;
    tick();
    vec_ready = 1'b0;
    chk(!vec_valid && !hold_wait, "R9", {vec_valid, hold_wait}, 0);
    tick();
    chk(!vec_valid, "R9", vec_valid, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule